// File: doc/BRIEF.md
# Bridge Window and Bus-Range Decoder

This block makes the forwarding decision for a bridge between two parallel expansion buses. Software programs it through a small register port with the bus numbering (upstream bus, first downstream bus, last downstream bus, and a latency value for the downstream side) and three address windows: one for 16-bit I/O space, one for memory, and one for prefetchable memory. Each window is a base/limit pair at coarse granularity. The I/O window works in 4 KiB steps and the two memory windows in 1 MiB steps. The base gives the upper address bits with the lower bits read as zero. The limit gives the upper bits with the lower bits read as all ones. A window whose base is greater than its limit claims nothing.

Each upstream transaction is presented on a decode stream as an address, a space code and, for configuration cycles, a target bus number. The block returns one result per request. The result says whether the transaction is claimed and forwarded downstream, and for a configuration cycle whether it becomes a device-level (type 0) cycle on the first downstream bus or is passed on unchanged (type 1) to a deeper bus. The decode stream is valid/ready on both sides. A request is accepted on a clock edge where `dec_valid` and `dec_ready` are both high. Its result appears on `res_valid` one cycle later and stays there until `res_ready` is high at a clock edge. `dec_ready` is high whenever no result is waiting or the waiting one is being taken in that cycle, so a stalled consumer stops new requests and loses no result.

Top module: `p2p_window_decode`

## Requirements
- R1: After reset the command enables are 0, all bus numbers and the latency value are 0, and every window is disabled. The register reads are: index 0 gives 0x0000, 1 gives 0x0000, 2 gives 0x0000, 3 gives 0x000F, 4 gives 0x0FFF, 5 gives 0x0000, 6 gives 0x0FFF and 7 gives 0x0000.
- R2: The register map uses `cfg_addr` as follows. Index 0 is the command register, with bit 0 as the I/O enable and bit 1 as the memory enable. Index 1 holds the upstream bus in [7:0] and the first downstream bus in [15:8]. Index 2 holds the last downstream bus in [7:0] and the latency value in [15:8]. Index 3 holds the I/O base in [3:0] and the I/O limit in [11:8]. Indexes 4, 5, 6 and 7 hold, in [11:0], the memory base, memory limit, prefetchable base and prefetchable limit. A write takes effect at the clock edge, reads are combinational, and bits not listed read as zero.
- R3: A memory access (space code 0) is claimed when the memory enable is set and address bits [31:20] lie between the memory base and memory limit, inclusive.
- R4: A memory access is also claimed when the memory enable is set and address bits [31:20] lie between the prefetchable base and limit, inclusive. A hit in either window is enough.
- R5: An I/O access (space code 1) is claimed only when the I/O enable is set, address bits [31:16] are zero, and bits [15:12] lie between the I/O base and limit, inclusive. The memory windows play no part in I/O decoding.
- R6: A window whose base is greater than its limit claims no address.
- R7: With the memory enable clear no memory access is claimed, and with the I/O enable clear no I/O access is claimed.
- R8: A configuration cycle (space code 2) whose bus number equals the first downstream bus is claimed with `res_type0` high and `res_type1` low.
- R9: A configuration cycle whose bus number is above the first downstream bus and at or below the last downstream bus is claimed with `res_type1` high. Any other bus number is not claimed, and both type outputs are low.
- R10: Space code 3 is never claimed. For memory and I/O results, and for any result that is not claimed, both type outputs are low.
- R11: A result appears one cycle after its request is accepted. While `res_valid` is high and `res_ready` is low, `dec_ready` is low and the result outputs hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data for `cfg_addr` |
| dec_valid | input | 1 | Decode request valid |
| dec_ready | output | 1 | Decode request accepted when high with valid |
| dec_addr | input | 32 | Transaction address |
| dec_space | input | 2 | Space code: 0 memory, 1 I/O, 2 configuration, 3 reserved |
| dec_bus | input | 8 | Target bus number of a configuration cycle |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_fwd | output | 1 | Transaction claimed and forwarded downstream |
| res_type0 | output | 1 | Configuration cycle becomes a device-level cycle |
| res_type1 | output | 1 | Configuration cycle is passed on to a deeper bus |

## Verification
The hardest cases to reach are the edges of each window. These are the first and last 1 MiB or 4 KiB step, with the low address bits set to all zeros and to all ones. They must be hit together with a second window that is either adjacent or disabled by an inverted base and limit. The bench programs a small configuration with a single-step memory window and a narrow prefetchable window. It sweeps the upper address bits step by step across both edges and alternates the low bits, then repeats the sweep with the prefetchable window inverted. The bus-range rule is checked over all 256 bus numbers. A stall case holds `res_ready` low while a second, differing request waits, to show that the first result is not overwritten.

// File: rtl/p2p_win_pkg.sv
package p2p_win_pkg;
  typedef enum logic [1:0] {
    SP_MEM  = 2'd0,
    SP_IO   = 2'd1,
    SP_CFG1 = 2'd2,
    SP_RSVD = 2'd3
  } space_e;

  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] RI_CMD    = 3'd0;
  localparam logic [REG_AW-1:0] RI_BUS_A  = 3'd1;
  localparam logic [REG_AW-1:0] RI_BUS_B  = 3'd2;
  localparam logic [REG_AW-1:0] RI_IO     = 3'd3;
  localparam logic [REG_AW-1:0] RI_MBASE  = 3'd4;
  localparam logic [REG_AW-1:0] RI_MLIM   = 3'd5;
  localparam logic [REG_AW-1:0] RI_PBASE  = 3'd6;
  localparam logic [REG_AW-1:0] RI_PLIM   = 3'd7;
endpackage

// File: rtl/p2p_win_regs.sv
module p2p_win_regs
  import p2p_win_pkg::*;
#(
  parameter int BUS_W    = 8,
  parameter int MEM_HI_W = 12,
  parameter int IO_HI_W  = 4,
  parameter int REG_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [REG_AW-1:0]   addr,
  input  logic [REG_W-1:0]    wdata,
  output logic [REG_W-1:0]    rdata,
  output logic                io_en,
  output logic                mem_en,
  output logic [BUS_W-1:0]    sec_bus,
  output logic [BUS_W-1:0]    sub_bus,
  output logic [IO_HI_W-1:0]  io_base,
  output logic [IO_HI_W-1:0]  io_lim,
  output logic [MEM_HI_W-1:0] mem_base,
  output logic [MEM_HI_W-1:0] mem_lim,
  output logic [MEM_HI_W-1:0] pf_base,
  output logic [MEM_HI_W-1:0] pf_lim
);
  localparam int HI_OFS = REG_W / 2;

  logic [BUS_W-1:0] pri_bus;
  logic [BUS_W-1:0] lat_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_en    <= 1'b0;
      mem_en   <= 1'b0;
      pri_bus  <= '0;
      sec_bus  <= '0;
      sub_bus  <= '0;
      lat_val  <= '0;
      io_base  <= '1;
      io_lim   <= '0;
      mem_base <= '1;
      mem_lim  <= '0;
      pf_base  <= '1;
      pf_lim   <= '0;
    end else if (we) begin
      case (addr)
        RI_CMD: begin
          io_en  <= wdata[0];
          mem_en <= wdata[1];
        end
        RI_BUS_A: begin
          pri_bus <= wdata[BUS_W-1:0];
          sec_bus <= wdata[HI_OFS +: BUS_W];
        end
        RI_BUS_B: begin
          sub_bus <= wdata[BUS_W-1:0];
          lat_val <= wdata[HI_OFS +: BUS_W];
        end
        RI_IO: begin
          io_base <= wdata[IO_HI_W-1:0];
          io_lim  <= wdata[HI_OFS +: IO_HI_W];
        end
        RI_MBASE: mem_base <= wdata[MEM_HI_W-1:0];
        RI_MLIM:  mem_lim  <= wdata[MEM_HI_W-1:0];
        RI_PBASE: pf_base  <= wdata[MEM_HI_W-1:0];
        default:  pf_lim   <= wdata[MEM_HI_W-1:0];
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      RI_CMD: begin
        rdata[0] = io_en;
        rdata[1] = mem_en;
      end
      RI_BUS_A: begin
        rdata[BUS_W-1:0]       = pri_bus;
        rdata[HI_OFS +: BUS_W] = sec_bus;
      end
      RI_BUS_B: begin
        rdata[BUS_W-1:0]       = sub_bus;
        rdata[HI_OFS +: BUS_W] = lat_val;
      end
      RI_IO: begin
        rdata[IO_HI_W-1:0]       = io_base;
        rdata[HI_OFS +: IO_HI_W] = io_lim;
      end
      RI_MBASE: rdata[MEM_HI_W-1:0] = mem_base;
      RI_MLIM:  rdata[MEM_HI_W-1:0] = mem_lim;
      RI_PBASE: rdata[MEM_HI_W-1:0] = pf_base;
      default:  rdata[MEM_HI_W-1:0] = pf_lim;
    endcase
  end

  // R2
  cmd_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == RI_CMD) |=> (io_en == $past(wdata[0]) && mem_en == $past(wdata[1])));
endmodule

// File: rtl/p2p_win_cmp.sv
module p2p_win_cmp #(
  parameter int W = 12
) (
  input  logic [W-1:0] val,
  input  logic [W-1:0] base,
  input  logic [W-1:0] lim,
  output logic         hit
);
  assign hit = (val >= base) && (val <= lim);
endmodule

// File: rtl/p2p_bus_route.sv
module p2p_bus_route #(
  parameter int BUS_W = 8
) (
  input  logic [BUS_W-1:0] bus,
  input  logic [BUS_W-1:0] sec_bus,
  input  logic [BUS_W-1:0] sub_bus,
  output logic             to_type0,
  output logic             to_type1
);
  assign to_type0 = (bus == sec_bus);
  assign to_type1 = (bus > sec_bus) && (bus <= sub_bus);
endmodule

// File: rtl/p2p_window_decode.sv
module p2p_window_decode
  import p2p_win_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int IO_ADDR_W  = 16,
  parameter int MEM_GRAN_W = 20,
  parameter int IO_GRAN_W  = 12,
  parameter int BUS_W      = 8,
  parameter int REG_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              dec_valid,
  output logic              dec_ready,
  input  logic [ADDR_W-1:0] dec_addr,
  input  logic [1:0]        dec_space,
  input  logic [BUS_W-1:0]  dec_bus,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_fwd,
  output logic              res_type0,
  output logic              res_type1
);
  localparam int MEM_HI_W = ADDR_W - MEM_GRAN_W;
  localparam int IO_HI_W  = IO_ADDR_W - IO_GRAN_W;
  localparam int N_MWIN   = 2;

  logic                io_en, mem_en;
  logic [BUS_W-1:0]    sec_bus, sub_bus;
  logic [IO_HI_W-1:0]  io_base, io_lim;
  logic [MEM_HI_W-1:0] mw_base [N_MWIN];
  logic [MEM_HI_W-1:0] mw_lim  [N_MWIN];
  logic [N_MWIN-1:0]   mw_hit;
  logic                io_hit;
  logic                io_upper_zero;
  logic                cfg_t0, cfg_t1;
  logic                unused_addr_low;

  p2p_win_regs #(
    .BUS_W(BUS_W), .MEM_HI_W(MEM_HI_W), .IO_HI_W(IO_HI_W), .REG_W(REG_W)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata),
    .io_en(io_en), .mem_en(mem_en),
    .sec_bus(sec_bus), .sub_bus(sub_bus),
    .io_base(io_base), .io_lim(io_lim),
    .mem_base(mw_base[0]), .mem_lim(mw_lim[0]),
    .pf_base(mw_base[1]), .pf_lim(mw_lim[1])
  );

  for (genvar g = 0; g < N_MWIN; g++) begin : g_mwin
    p2p_win_cmp #(.W(MEM_HI_W)) cmp_i (
      .val(dec_addr[ADDR_W-1:MEM_GRAN_W]),
      .base(mw_base[g]), .lim(mw_lim[g]), .hit(mw_hit[g])
    );
  end

  p2p_win_cmp #(.W(IO_HI_W)) io_cmp_i (
    .val(dec_addr[IO_ADDR_W-1:IO_GRAN_W]),
    .base(io_base), .lim(io_lim), .hit(io_hit)
  );

  p2p_bus_route #(.BUS_W(BUS_W)) route_i (
    .bus(dec_bus), .sec_bus(sec_bus), .sub_bus(sub_bus),
    .to_type0(cfg_t0), .to_type1(cfg_t1)
  );

  assign io_upper_zero   = (dec_addr[ADDR_W-1:IO_ADDR_W] == '0);
  assign unused_addr_low = ^dec_addr[IO_GRAN_W-1:0];

  logic nx_fwd, nx_t0, nx_t1;

  always_comb begin
    nx_fwd = 1'b0;
    nx_t0  = 1'b0;
    nx_t1  = 1'b0;
    case (space_e'(dec_space))
      SP_MEM:  nx_fwd = mem_en && (|mw_hit);
      SP_IO:   nx_fwd = io_en && io_upper_zero && io_hit;
      SP_CFG1: begin
        nx_fwd = cfg_t0 || cfg_t1;
        nx_t0  = cfg_t0;
        nx_t1  = cfg_t1;
      end
      default: nx_fwd = 1'b0;
    endcase
  end

  logic accept;
  assign dec_ready = !res_valid || res_ready;
  assign accept    = dec_valid && dec_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_fwd   <= 1'b0;
      res_type0 <= 1'b0;
      res_type1 <= 1'b0;
    end else if (accept) begin
      res_valid <= 1'b1;
      res_fwd   <= nx_fwd;
      res_type0 <= nx_t0;
      res_type1 <= nx_t1;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  // R11
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_fwd)
                                   && $stable(res_type0) && $stable(res_type1)));

  // R7
  mem_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dec_space == SP_MEM && !mem_en) |=> !res_fwd);

  // R7
  io_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dec_space == SP_IO && !io_en) |=> !res_fwd);

  // R6
  both_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dec_space == SP_MEM && mw_base[0] > mw_lim[0]
     && mw_base[1] > mw_lim[1]) |=> !res_fwd);

  // R10
  rsvd_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dec_space == SP_RSVD) |=> (!res_fwd && !res_type0 && !res_type1));

  // R9
  type_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($onehot0({res_type0, res_type1})
                   && (!(res_type0 || res_type1) || res_fwd)));
endmodule

// File: tb/p2p_window_decode_tb.sv
module p2p_window_decode_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        dec_valid = 1'b0;
  logic        dec_ready;
  logic [31:0] dec_addr = '0;
  logic [1:0]  dec_space = '0;
  logic [7:0]  dec_bus = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_fwd, res_type0, res_type1;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  p2p_window_decode dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_addr(dec_addr),
    .dec_space(dec_space), .dec_bus(dec_bus),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_fwd(res_fwd), .res_type0(res_type0), .res_type1(res_type1)
  );

  // shadow of the programmed configuration
  bit        s_io_en, s_mem_en;
  logic [7:0]  s_sec, s_sub;
  logic [3:0]  s_iob, s_iol;
  logic [11:0] s_mb, s_ml, s_pb, s_pl;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    cfg_addr = a;
    #1;
    chk(cfg_rdata == exp, req, {16'h0, cfg_rdata}, {16'h0, exp});
  endtask

  task automatic dec(input logic [31:0] a, input logic [1:0] sp, input logic [7:0] b,
                     input bit ef, input bit e0, input bit e1, input string req);
    @(negedge clk);
    dec_addr = a; dec_space = sp; dec_bus = b; dec_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    dec_valid = 1'b0;
    chk({res_valid, res_fwd, res_type0, res_type1} == {1'b1, ef, e0, e1}, req,
        {28'h0, res_valid, res_fwd, res_type0, res_type1},
        {28'h0, 1'b1, ef, e0, e1});
  endtask

  function automatic bit exp_mem(input logic [31:0] a);
    logic [11:0] hi;
    hi = a[31:20];
    return s_mem_en && ((hi >= s_mb && hi <= s_ml) || (hi >= s_pb && hi <= s_pl));
  endfunction

  function automatic bit exp_io(input logic [31:0] a);
    return s_io_en && (a[31:16] == 16'h0) && (a[15:12] >= s_iob) && (a[15:12] <= s_iol);
  endfunction

  task automatic set_cmd(input bit io, input bit mem);
    s_io_en = io; s_mem_en = mem;
    wr(3'd0, {14'h0, mem, io});
  endtask

  task automatic set_mem(input logic [11:0] mb, input logic [11:0] ml,
                         input logic [11:0] pb, input logic [11:0] pl);
    s_mb = mb; s_ml = ml; s_pb = pb; s_pl = pl;
    wr(3'd4, {4'h0, mb}); wr(3'd5, {4'h0, ml});
    wr(3'd6, {4'h0, pb}); wr(3'd7, {4'h0, pl});
  endtask

  task automatic mem_sweep(input int lo, input int hi, input string req);
    for (int h = lo; h <= hi; h++) begin
      logic [31:0] a;
      a = {h[11:0], ((h % 2) == 1) ? 20'hFFFFF : 20'h00000};
      dec(a, 2'd0, 8'h0, exp_mem(a), 1'b0, 1'b0, req);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    s_io_en = 0; s_mem_en = 0; s_sec = 0; s_sub = 0;
    s_iob = 4'hF; s_iol = 4'h0;
    s_mb = 12'hFFF; s_ml = 0; s_pb = 12'hFFF; s_pl = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset register values
    rd(3'd0, 16'h0000, "R1"); rd(3'd1, 16'h0000, "R1");
    rd(3'd2, 16'h0000, "R1"); rd(3'd3, 16'h000F, "R1");
    rd(3'd4, 16'h0FFF, "R1"); rd(3'd5, 16'h0000, "R1");
    rd(3'd6, 16'h0FFF, "R1"); rd(3'd7, 16'h0000, "R1");
    chk(res_valid == 1'b0, "R1", {31'h0, res_valid}, 32'h0);

    // R1/R6: enables on, windows still in reset state -> nothing claimed
    set_cmd(1'b1, 1'b1);
    for (int h = 0; h < 4096; h += 37)
      dec({h[11:0], 20'h0}, 2'd0, 8'h0, 1'b0, 1'b0, 1'b0, "R1");
    for (int n = 0; n < 16; n++)
      dec({16'h0, n[3:0], 12'h0}, 2'd1, 8'h0, 1'b0, 1'b0, 1'b0, "R1");

    // R2 write masking and field placement
    wr(3'd0, 16'hFFFF); rd(3'd0, 16'h0003, "R2");
    wr(3'd3, 16'hFFFF); rd(3'd3, 16'h0F0F, "R2");
    wr(3'd4, 16'hFFFF); rd(3'd4, 16'h0FFF, "R2");
    wr(3'd1, 16'hA512); rd(3'd1, 16'hA512, "R2");
    wr(3'd2, 16'h40C7); rd(3'd2, 16'h40C7, "R2");
    wr(3'd7, 16'hF123); rd(3'd7, 16'h0123, "R2");

    // R3/R4: single-step memory window and a 16-step prefetchable window
    set_cmd(1'b1, 1'b1);
    set_mem(12'h808, 12'h808, 12'h900, 12'h90F);
    mem_sweep(12'h7F0, 12'h920, "R3_R4");
    dec(32'h808FFFFF, 2'd0, 8'h0, 1'b1, 1'b0, 1'b0, "R3");
    dec(32'h80900000, 2'd0, 8'h0, 1'b0, 1'b0, 1'b0, "R3");
    dec(32'h90FFFFFF, 2'd0, 8'h0, 1'b1, 1'b0, 1'b0, "R4");

    // R6: prefetchable base above limit, adjacent to memory window
    set_mem(12'h808, 12'h80F, 12'h810, 12'h80F);
    mem_sweep(12'h800, 12'h820, "R6");
    // R6: memory window inverted, prefetchable active
    set_mem(12'h001, 12'h000, 12'hC00, 12'hC03);
    mem_sweep(12'h000, 12'h002, "R6");
    mem_sweep(12'hBFE, 12'hC05, "R4");

    // R7: memory enable clear
    set_cmd(1'b1, 1'b0);
    mem_sweep(12'hBFE, 12'hC05, "R7");

    // R5: I/O window 0x1000..0x3FFF
    set_cmd(1'b1, 1'b1);
    s_iob = 4'h1; s_iol = 4'h3;
    wr(3'd3, 16'h0301);
    for (int n = 0; n < 32; n++) begin
      logic [31:0] a;
      a = {16'h0, n[3:0], n[4] ? 12'hFFF : 12'h000};
      dec(a, 2'd1, 8'h0, exp_io(a), 1'b0, 1'b0, "R5");
    end
    dec(32'h00011000, 2'd1, 8'h0, 1'b0, 1'b0, 1'b0, "R5");
    dec(32'h80002000, 2'd1, 8'h0, 1'b0, 1'b0, 1'b0, "R5");
    // R5: memory address inside a memory window is not an I/O hit
    dec(32'hC0000000, 2'd1, 8'h0, 1'b0, 1'b0, 1'b0, "R5");
    // I/O address as memory space: no memory window covers 0x000
    dec(32'h00002000, 2'd0, 8'h0, 1'b0, 1'b0, 1'b0, "R5");

    // R7: I/O enable clear
    set_cmd(1'b0, 1'b1);
    for (int n = 0; n < 16; n++)
      dec({16'h0, n[3:0], 12'h800}, 2'd1, 8'h0, 1'b0, 1'b0, 1'b0, "R7");

    // R8/R9: downstream buses 3..6, all bus numbers
    s_sec = 8'd3; s_sub = 8'd6;
    wr(3'd1, 16'h0300); wr(3'd2, 16'h0006);
    for (int b = 0; b < 256; b++) begin
      bit t0, t1;
      t0 = (b == 3);
      t1 = (b > 3) && (b <= 6);
      dec(32'h0, 2'd2, b[7:0], t0 || t1, t0, t1, t0 ? "R8" : "R9");
    end
    // R8/R9: first and last downstream bus equal
    wr(3'd1, 16'h0500); wr(3'd2, 16'h0005);
    dec(32'h0, 2'd2, 8'd5, 1'b1, 1'b1, 1'b0, "R8");
    dec(32'h0, 2'd2, 8'd6, 1'b0, 1'b0, 1'b0, "R9");
    dec(32'h0, 2'd2, 8'd4, 1'b0, 1'b0, 1'b0, "R9");

    // R10: reserved space never claimed, even inside windows
    set_cmd(1'b1, 1'b1);
    dec(32'hC0100000, 2'd3, 8'd5, 1'b0, 1'b0, 1'b0, "R10");
    dec(32'h00001000, 2'd3, 8'd5, 1'b0, 1'b0, 1'b0, "R10");
    dec(32'hC0100000, 2'd0, 8'd5, 1'b1, 1'b0, 1'b0, "R10");

    // R11: stall holds the result and blocks the next request
    @(negedge clk); res_ready = 1'b0;
    dec(32'hC0200000, 2'd0, 8'h0, 1'b1, 1'b0, 1'b0, "R11");
    @(negedge clk);
    dec_addr = 32'h00000000; dec_space = 2'd0; dec_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk({res_valid, res_fwd, dec_ready} == 3'b110, "R11",
          {29'h0, res_valid, res_fwd, dec_ready}, 32'h6);
    end
    res_ready = 1'b1;
    #1;
    chk(dec_ready == 1'b1, "R11", {31'h0, dec_ready}, 32'h1);
    @(posedge clk);
    @(negedge clk);
    dec_valid = 1'b0;
    chk({res_valid, res_fwd} == 2'b10, "R11", {30'h0, res_valid, res_fwd}, 32'h2);
    @(negedge clk);
    chk(res_valid == 1'b0, "R11", {31'h0, res_valid}, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule